// File: doc/BRIEF.md
# Field Memory Write Port Controller

This block drives the write side of a field delay memory whose addressing is restarted by a reset-write pulse. On each write clock it turns a reset-write request, a write enable, an input enable and a data byte into an address, a write strobe and write data for a synchronous memory array. The memory stores the data on the same clock edge. Because the pointer is restarted by the reset-write request, the distance between the write and read restarts sets the delay of the field memory.

The two enables behave differently. Write enable gates the whole cycle: with it inactive, the pointer holds and nothing is stored. Input enable only masks the store: the pointer still advances, so selected locations keep their old contents. This is useful for overlaying one picture inside another. Two straps are captured while the system reset is asserted. The polarity strap makes every control input active low. The cascade strap delays all controls and data by one register stage, so that devices in a chain line up without external delay elements.

A sticky protocol-error flag records two misuses. The first is a reset-write request that arrives too soon after the previous one. The second is a write series that holds too few stored cycles between two reset-write requests.

Top module: `fmw_write_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, the pointer clears to 0, the pipeline stage clears to the inactive state and the error flag clears. In the first cycle after release, with idle inputs, `mem_addr` is 0, `mem_we` is 0 and `proto_err` is 0.
- R2: In any cycle whose effective reset-write is asserted, `mem_we` is 0 whatever the enables are, and in the next cycle `mem_addr` is 0.
- R3: In a cycle with effective write enable asserted and no reset-write, the pointer advances by one at the clock edge. With write enable deasserted, the pointer holds and `mem_we` is 0 whatever the input enable is.
- R4: With write enable asserted, `mem_we` equals the effective input enable. The pointer advances whether or not the input enable is asserted.
- R5: The pointer counts from 0 to DEPTH-1 and then wraps to 0. `mem_addr` is never DEPTH or above.
- R6: With the polarity strap captured as 1, a control input is asserted when it is 0. With the strap captured as 0, a control input is asserted when it is 1.
- R7: With the cascade strap captured as 0, `mem_we`, `mem_addr` and `mem_wdata` respond to the control and data inputs of the same cycle. With the strap captured as 1, they respond to the inputs of the previous cycle.
- R8: A reset-write rising edge that follows fewer than RST_GAP (default 2) consecutive deasserted cycles sets `proto_err`. These cycles are counted from the previous reset-write or from system reset.
- R9: A reset-write rising edge that closes a series started by an earlier reset-write sets `proto_err` if fewer than MIN_ACTIVE (default 140) cycles of that series stored data. Exactly MIN_ACTIVE stored cycles do not set it.
- R10: Once set, `proto_err` stays 1 until the next system reset.
- R11: Changes on the strap pins after system reset has been released have no effect until the next system reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge |
| rst_n | input | 1 | Synchronous active-low system reset; straps are captured while it is low |
| strap_pol | input | 1 | Polarity strap: 1 makes the control inputs active low |
| strap_cas | input | 1 | Cascade strap: 1 adds one pipeline stage on the controls and data |
| wr_rst | input | 1 | Reset-write request |
| wr_en | input | 1 | Write enable: advances the pointer and allows the store |
| in_en | input | 1 | Input enable: allows the store only |
| din | input | DATA_W | Write data |
| mem_addr | output | $clog2(DEPTH) | Write address toward the memory array |
| mem_we | output | 1 | Write strobe, stored on the rising clock edge |
| mem_wdata | output | DATA_W | Write data toward the memory array |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
Some behaviours are checked by assertions in every cycle. These are the pointer rules: it returns to zero after a reset-write, holds without write enable, steps by one with wrap, and stays inside the depth. The assertions also check the strap capture, the inversion of the controls under the polarity strap, the gap error and the stickiness of the error flag. Other behaviours only show up in the bench's scenarios. These are the store pattern as input enable varies, the one-cycle shift under the cascade strap, and the exact boundary of the minimum-series rule at MIN_ACTIVE versus MIN_ACTIVE-1 stored cycles. The same holds for strap pins that toggle mid-run and for wrap-around under masked stores.

// File: rtl/fmw_pkg.sv
// Shared types for the field memory write port.
// Assumes: controls are carried already normalised to active-high.
package fmw_pkg;

    // One cycle of normalised (active-high) write controls.
    typedef struct packed {
        logic rst;   // reset-write request
        logic we;    // write enable: gates pointer and store
        logic ie;    // input enable: gates store only
    } fmw_ctl_t;

    localparam int CTL_W = $bits(fmw_ctl_t);

endpackage

// File: rtl/fmw_ctrl_stage.sv
// Control front end: captures the straps during system reset, turns the raw
// controls into active-high form, and optionally delays controls and data
// by one register stage (cascade).
// Assumes: straps are static after reset; rst_n is synchronous, active low.
module fmw_ctrl_stage
    import fmw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_pol,
    input  logic              strap_cas,
    input  logic              raw_rst,
    input  logic              raw_we,
    input  logic              raw_ie,
    input  logic [DATA_W-1:0] raw_data,
    output fmw_ctl_t          eff_ctl,
    output logic [DATA_W-1:0] eff_data
);

    logic              pol_q;
    logic              cas_q;
    fmw_ctl_t          raw_ctl;
    fmw_ctl_t          norm_ctl;
    fmw_ctl_t          pipe_ctl;
    logic [DATA_W-1:0] pipe_data;

    // Capture the straps while system reset is held; freeze them afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= strap_pol;
            cas_q <= strap_cas;
        end
    end

    // Map the raw pins to active-high form according to the polarity strap.
    always_comb begin
        raw_ctl.rst = raw_rst;
        raw_ctl.we  = raw_we;
        raw_ctl.ie  = raw_ie;
        norm_ctl    = fmw_ctl_t'(raw_ctl ^ {CTL_W{pol_q}});
    end

    // Cascade register stage for the normalised controls and the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_ctl  <= '0;
            pipe_data <= '0;
        end else begin
            pipe_ctl  <= norm_ctl;
            pipe_data <= raw_data;
        end
    end

    // Pick the direct or the delayed view according to the cascade strap.
    always_comb begin
        if (cas_q) begin
            eff_ctl  = pipe_ctl;
            eff_data = pipe_data;
        end else begin
            eff_ctl  = norm_ctl;
            eff_data = raw_data;
        end
    end

    // R11
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(pol_q) && $stable(cas_q)));

    // R6
    pol_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_q && pol_q) |-> (eff_ctl.we == !raw_we && eff_ctl.rst == !raw_rst));

endmodule

// File: rtl/fmw_addr_gen.sv
// Write address pointer: cleared by reset-write, advanced by write enable,
// wrapping from DEPTH-1 to 0. Input enable has no influence here.
// Assumes: controls arrive active-high from the control front end.
module fmw_addr_gen
    import fmw_pkg::*;
#(
    parameter int DEPTH = 262144,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fmw_ctl_t      eff_ctl,
    output logic [AW-1:0] ptr
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [AW-1:0] ptr_inc;

    // Next sequential address with wrap at the configured depth.
    always_comb begin
        ptr_inc = (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    // Pointer register: reset-write dominates, then write enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (eff_ctl.rst) begin
            ptr <= '0;
        end else if (eff_ctl.we) begin
            ptr <= ptr_inc;
        end
    end

    // R2
    ptr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(eff_ctl.rst)) |-> (ptr == '0));

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(eff_ctl.we && !eff_ctl.rst)) |->
            (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)));

    // R3
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!eff_ctl.we && !eff_ctl.rst)) |-> $stable(ptr));

    // R5
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST);

endmodule

// File: rtl/fmw_proto_mon.sv
// Protocol monitor: flags a reset-write that follows too few idle cycles,
// and a write series that stored fewer than MIN_ACTIVE words. Sticky flag.
// Assumes: the idle count starts at zero after system reset.
module fmw_proto_mon
    import fmw_pkg::*;
#(
    parameter int MIN_ACTIVE = 140,
    parameter int RST_GAP    = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  fmw_ctl_t eff_ctl,
    output logic     err
);

    localparam int LW = $clog2(RST_GAP + 1);
    localparam int CW = $clog2(MIN_ACTIVE + 1);
    localparam logic [LW-1:0] GAP_V = LW'(RST_GAP);
    localparam logic [CW-1:0] MIN_V = CW'(MIN_ACTIVE);

    logic          prev_rst;
    logic [LW-1:0] low_cnt;
    logic [CW-1:0] act_cnt;
    logic          series_open;
    logic          rise;
    logic          gap_bad;
    logic          short_bad;
    logic          stored;

    // Classify the current cycle.
    always_comb begin
        rise      = eff_ctl.rst && !prev_rst;
        stored    = !eff_ctl.rst && eff_ctl.we && eff_ctl.ie;
        gap_bad   = rise && (low_cnt < GAP_V);
        short_bad = rise && series_open && (act_cnt < MIN_V);
    end

    // Track reset-write level and the run of idle cycles (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_rst <= 1'b0;
            low_cnt  <= '0;
        end else begin
            prev_rst <= eff_ctl.rst;
            if (eff_ctl.rst) begin
                low_cnt <= '0;
            end else if (low_cnt < GAP_V) begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end

    // Count stored cycles within the current series (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_cnt     <= '0;
            series_open <= 1'b0;
        end else if (rise) begin
            act_cnt     <= '0;
            series_open <= 1'b1;
        end else if (stored && act_cnt < MIN_V) begin
            act_cnt <= act_cnt + 1'b1;
        end
    end

    // Sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else if (gap_bad || short_bad) begin
            err <= 1'b1;
        end
    end

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(err)) |-> err);

    // R8
    gap_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && eff_ctl.rst &&
         !$past(eff_ctl.rst) && $past(eff_ctl.rst, 2)) |=> err);

endmodule

// File: rtl/fmw_write_port.sv
// Field memory write port controller (top). Joins the control front end,
// the address generator and the protocol monitor, and drives the write
// interface of a synchronous memory array that stores on the rising edge.
// Assumes: the array samples mem_addr/mem_we/mem_wdata at the clock edge.
module fmw_write_port
    import fmw_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int DEPTH      = 262144,
    parameter int MIN_ACTIVE = 140,
    parameter int RST_GAP    = 2,
    parameter int AW         = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_pol,
    input  logic              strap_cas,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic              in_en,
    input  logic [DATA_W-1:0] din,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              proto_err
);

    fmw_ctl_t          eff_ctl;
    logic [DATA_W-1:0] eff_data;
    logic [AW-1:0]     ptr;

    fmw_ctrl_stage #(
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_pol (strap_pol),
        .strap_cas (strap_cas),
        .raw_rst   (wr_rst),
        .raw_we    (wr_en),
        .raw_ie    (in_en),
        .raw_data  (din),
        .eff_ctl   (eff_ctl),
        .eff_data  (eff_data)
    );

    fmw_addr_gen #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .eff_ctl (eff_ctl),
        .ptr     (ptr)
    );

    fmw_proto_mon #(
        .MIN_ACTIVE (MIN_ACTIVE),
        .RST_GAP    (RST_GAP)
    ) u_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .eff_ctl (eff_ctl),
        .err     (proto_err)
    );

    // Memory-side write interface; no store during system or write reset.
    always_comb begin
        mem_addr  = ptr;
        mem_wdata = eff_data;
        mem_we    = rst_n && !eff_ctl.rst && eff_ctl.we && eff_ctl.ie;
    end

endmodule

// File: tb/fmw_write_port_bench.sv
// Bench: random enable/data streams under all strap settings, plus directed
// protocol corners, compared each cycle with a reference model.
module fmw_write_port_bench;

    localparam int D    = 256;
    localparam int MINA = 140;
    localparam int AW   = $clog2(D);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          strap_pol, strap_cas;
    logic          wr_rst, wr_en, in_en;
    logic [7:0]    din;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [7:0]    mem_wdata;
    logic          proto_err;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    int       mptr, mlow, mact;
    bit [2:0] mpipe;       // {rst, we, ie}
    bit [7:0] mpd;
    bit       mprev, merr, mopen, mpol, mcas;

    always #10 clk = ~clk;

    fmw_write_port #(
        .DATA_W (8), .DEPTH (D), .MIN_ACTIVE (MINA), .RST_GAP (2)
    ) u_fmw_write_port (
        .clk (clk), .rst_n (rst_n), .strap_pol (strap_pol), .strap_cas (strap_cas),
        .wr_rst (wr_rst), .wr_en (wr_en), .in_en (in_en), .din (din),
        .mem_addr (mem_addr), .mem_we (mem_we), .mem_wdata (mem_wdata),
        .proto_err (proto_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int next_ptr(input int p);
        return (p == D - 1) ? 0 : p + 1;
    endfunction

    // System reset with given straps (R1, R11 capture). Ends at a negedge.
    task automatic sys_reset(input bit p, input bit c);
        @(negedge clk);
        strap_pol = p; strap_cas = c; rst_n = 1'b0;
        wr_rst = p; wr_en = p; in_en = p; din = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mptr = 0; mlow = 0; mact = 0; mpipe = '0; mpd = '0;
        mprev = 0; merr = 0; mopen = 0; mpol = p; mcas = c;
    endtask

    // One cycle with active-high intent; encoded by the captured polarity (R6).
    task automatic step(input bit r, input bit w, input bit i, input bit [7:0] d);
        bit er, ew, ei, ewe, rise;
        bit [7:0] ed;
        wr_rst = r ^ mpol; wr_en = w ^ mpol; in_en = i ^ mpol; din = d;
        #2;
        // R7: cascade selects previous-cycle inputs
        if (mcas) begin
            er = mpipe[2]; ew = mpipe[1]; ei = mpipe[0]; ed = mpd;
        end else begin
            er = r; ew = w; ei = i; ed = d;
        end
        ewe = !er && ew && ei;             // R2, R4
        chk("R3 R5 address", int'(mem_addr), mptr);
        chk("R4 strobe", int'(mem_we), int'(ewe));
        if (ewe) chk("R7 data", int'(mem_wdata), int'(ed));
        chk("R9 error flag", int'(proto_err), int'(merr));
        // model update at the coming edge
        rise = er && !mprev;
        if (rise) begin
            if (mlow < 2) merr = 1;                  // R8
            if (mopen && mact < MINA) merr = 1;      // R9
            mopen = 1; mact = 0;
        end else if (ewe && mact < MINA) begin
            mact++;
        end
        mlow  = er ? 0 : ((mlow < 2) ? mlow + 1 : 2);
        mprev = er;
        if (er) mptr = 0;
        else if (ew) mptr = next_ptr(mptr);
        mpipe = {r, w, i}; mpd = d;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 8'h00);
    endtask

    task automatic run_random(input int n);
        for (int k = 0; k < n; k++) begin
            bit r;
            if (k == n / 2) begin
                // R11: strap pins flip mid-run; model keeps captured values
                strap_pol = ~strap_pol; strap_cas = ~strap_cas;
            end
            r = (mlow >= 2) && !mprev && (!mopen || mact >= MINA) &&
                ($urandom % 60 == 0);
            step(r, ($urandom % 4) != 0, ($urandom % 3) != 0, 8'($urandom));
        end
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        rst_n = 1'b0; strap_pol = 0; strap_cas = 0;
        wr_rst = 0; wr_en = 0; in_en = 0; din = 0;

        // R1, R6, R7, R11: all strap combinations with random traffic
        for (int s = 0; s < 4; s++) begin
            sys_reset(s[0], s[1]);
            step(0, 0, 0, 8'h00);                     // R1 reset state
            idle(2);
            step(1, 1, 1, 8'hAA);                     // R2 enables ignored
            run_random(1500);
        end

        // R8: reset-write in first cycle after system reset
        sys_reset(0, 0);
        step(1, 0, 0, 8'h00);
        step(0, 0, 0, 8'h00);
        chk("R8 early reset", int'(proto_err), 1);

        // R8: only one idle cycle between two requests
        sys_reset(1, 0);
        idle(2);
        step(1, 0, 0, 8'h00);
        step(0, 0, 0, 8'h00);
        step(1, 0, 0, 8'h00);
        step(0, 0, 0, 8'h00);
        chk("R8 short gap", int'(proto_err), 1);
        idle(20);
        chk("R10 sticky", int'(proto_err), 1);
        sys_reset(1, 0);
        step(0, 0, 0, 8'h00);
        chk("R10 cleared by system reset", int'(proto_err), 0);

        // R9 boundary: exactly MINA stores is fine, MINA-1 is not
        sys_reset(0, 1);
        idle(2);
        step(1, 0, 0, 8'h00);
        for (int k = 0; k < MINA; k++) step(0, 1, 1, 8'(k));
        idle(2);
        step(1, 0, 0, 8'h00);
        idle(3);
        chk("R9 exact minimum", int'(proto_err), 0);
        for (int k = 0; k < MINA - 1; k++) step(0, 1, 1, 8'(k));
        idle(2);
        step(1, 0, 0, 8'h00);
        idle(3);
        chk("R9 one short", int'(proto_err), 1);

        // R4, R5: masked stores still advance; full lap wraps to 0
        sys_reset(0, 0);
        idle(2);
        step(1, 0, 0, 8'h00);
        step(0, 1, 0, 8'h11);
        chk("R4 masked advance", int'(mem_addr), 1);
        for (int k = 1; k < D; k++) step(0, 1, k[0], 8'(k));
        chk("R5 wrap", int'(mem_addr), 0);
        // R3: write enable low holds pointer regardless of input enable
        step(0, 1, 1, 8'h22);
        step(0, 0, 1, 8'h33);
        step(0, 0, 0, 8'h44);
        chk("R3 hold", int'(mem_addr), 1);
        // R2: reset-write with enables active returns to 0
        step(1, 1, 1, 8'h55);
        chk("R2 pointer zero", int'(mem_addr), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule